// File: doc/BRIEF.md
# Error Signaling Aggregator

This block gathers one-cycle error pulses from many sources and holds each one in a sticky status flag. Software reads and clears these flags through a small synchronous register bus. The sources come in two severity classes.

- **Low-severity channels.** Each has two enables of its own: one lets it raise a level interrupt, and one lets it drive the shared active-low error pin.
- **High-severity channels.** These always drive the error pin and never raise the interrupt.

Once the pin is driven low, it stays low until software writes a release key. The key only takes effect when no cause of the pin is still present. A source that keeps signalling sets its flag again right after software clears it.

The pin can also go low long after an event. This happens when an old flag was never cleared and its pin enable is switched on later.

Top module: `err_aggr_top`

## Requirements
- R1: After reset, all flags and enables are zero, `errPinN` is 1, `irq` is 0 and `rdata` is 0.
- R2: A pulse on a low or high event input sets its flag at that clock edge. The flag reads back as a 1 at the matching bit of its status word. Writing a 1 to that bit clears the flag, and writing a 0 leaves it unchanged.
- R3: When an event and a clear of the same flag arrive in the same cycle, the flag ends up set.
- R4: If an event input stays high, its flag is set again in the cycle after software clears it.
- R5: `irq` is high whenever some low flag is set and its interrupt-enable bit is 1. High-severity flags never raise `irq`.
- R6: A low flag whose pin-enable bit is 1 drives `errPinN` to 0 one cycle after the flag is set. A low flag whose pin-enable bit is 0 leaves the pin at 1.
- R7: Any set high-severity flag drives `errPinN` to 0 one cycle after it is set, with no enable needed.
- R8: If a low flag is already set and its pin-enable bit is written to 1 later, `errPinN` goes to 0 one cycle after that write.
- R9: Once `errPinN` is 0, it stays 0 after all flags are cleared. It returns to 1 only after a write of the value 5 to the key address (8). A write of any other value to that address is ignored.
- R10: A key write of 5 is ignored while any pin-enabled low flag or any high flag is still set, and the pin stays at 0.
- R11: The register map uses word addresses as follows:
  - 0–1: pin-enable words.
  - 2–3: interrupt-enable words.
  - 4–5: low-severity status words.
  - 6–7: high-severity status words.
  - 8: key.

  Channel n sits in word n/32 at bit n%32. The value read appears on `rdata` on the clock edge that samples `rdEn`. Enable registers read back what was written, and unmapped addresses and the key address read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| loEvent | input | 64 | Low-severity event pulses, one per channel |
| hiEvent | input | 64 | High-severity event pulses, one per channel |
| wrEn | input | 1 | Register write strobe |
| rdEn | input | 1 | Register read strobe |
| addr | input | 4 | Register word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| errPinN | output | 1 | Active-low error pin |
| irq | output | 1 | Level interrupt |

## Verification
Two pairs of operations can fall in the same cycle.

- **Event pulse and clear of the same flag.** The bench drives an event pulse and a write-one-clear of the same flag on one edge. It judges the result by reading the status word back, expecting the set to win.
- **Key write and a live pin cause.** The bench issues a key write while an enabled flag is still pending, and expects the pin to stay low. It also holds a source high across a clear, and expects the flag to be set again on the next read.

A vector table covers the combinations of severity class, channel word, pin enable and interrupt enable. For each combination it checks the pin and the interrupt, and it checks that the pin is released afterwards.

// File: rtl/err_aggr_pkg.sv
package err_aggr_pkg;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_PIN,
    SEL_IRQ,
    SEL_LOST,
    SEL_HIST
  } regSel_e;

  localparam int IDX_W = 8;

  // strobes passed from control to datapath
  typedef struct packed {
    logic             wrStb;
    logic             rdStb;
    regSel_e          sel;
    logic [IDX_W-1:0] wordIdx;
    logic             keyOk;
  } ctrlStrb_t;

endpackage

// File: rtl/err_aggr_ctrl.sv
module err_aggr_ctrl
  import err_aggr_pkg::*;
#(
  parameter int ADDR_W   = 4,
  parameter int DW       = 32,
  parameter int LO_WORDS = 2,
  parameter int HI_WORDS = 2,
  parameter int KEY_VAL  = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DW-1:0]     wdata,
  input  logic              pinCause,
  output ctrlStrb_t         strb,
  output logic              pinActive
);

  localparam int IRQ_BASE  = LO_WORDS;
  localparam int LOST_BASE = 2 * LO_WORDS;
  localparam int HIST_BASE = 3 * LO_WORDS;
  localparam int KEY_ADDR  = 3 * LO_WORDS + HI_WORDS;

  int a;

  always_comb begin
    a            = int'(addr);
    strb         = '0;
    strb.wrStb   = wrEn;
    strb.rdStb   = rdEn;
    strb.sel     = SEL_NONE;
    strb.wordIdx = '0;

    if (a < IRQ_BASE) begin
      strb.sel     = SEL_PIN;
      strb.wordIdx = IDX_W'(a);
    end else if (a < LOST_BASE) begin
      strb.sel     = SEL_IRQ;
      strb.wordIdx = IDX_W'(a - IRQ_BASE);
    end else if (a < HIST_BASE) begin
      strb.sel     = SEL_LOST;
      strb.wordIdx = IDX_W'(a - LOST_BASE);
    end else if (a < KEY_ADDR) begin
      strb.sel     = SEL_HIST;
      strb.wordIdx = IDX_W'(a - HIST_BASE);
    end

    strb.keyOk = wrEn && (a == KEY_ADDR) && (wdata == DW'(KEY_VAL));
  end

  // pin latch: a cause sets it, a key releases it only when no cause remains
  always_ff @(posedge clk) begin
    if (!rstN)
      pinActive <= 1'b0;
    else if (pinCause)
      pinActive <= 1'b1;
    else if (strb.keyOk)
      pinActive <= 1'b0;
  end

  // R9
  pin_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pinActive && !strb.keyOk) |=> pinActive);

  // R10
  key_block_chk: assert property (@(posedge clk) disable iff (!rstN)
    pinCause |=> pinActive);

endmodule

// File: rtl/err_aggr_datapath.sv
module err_aggr_datapath
  import err_aggr_pkg::*;
#(
  parameter int DW       = 32,
  parameter int LO_WORDS = 2,
  parameter int HI_WORDS = 2,
  localparam int NLO     = DW * LO_WORDS,
  localparam int NHI     = DW * HI_WORDS
) (
  input  logic           clk,
  input  logic           rstN,
  input  ctrlStrb_t      strb,
  input  logic [DW-1:0]  wdata,
  input  logic [NLO-1:0] loEvent,
  input  logic [NHI-1:0] hiEvent,
  output logic [DW-1:0]  rdata,
  output logic           pinCause,
  output logic           irq
);

  logic [DW-1:0] pinEn  [LO_WORDS];
  logic [DW-1:0] irqEn  [LO_WORDS];
  logic [DW-1:0] loFlag [LO_WORDS];
  logic [DW-1:0] hiFlag [HI_WORDS];

  logic [NLO-1:0] loFlagV, pinEnV, irqEnV;
  logic [NHI-1:0] hiFlagV;
  logic [DW-1:0]  rdMux;

  for (genvar w = 0; w < LO_WORDS; w++) begin : g_lo
    logic hitW;
    logic [DW-1:0] clrMask;

    assign hitW    = strb.wrStb && (strb.wordIdx == IDX_W'(w));
    assign clrMask = (hitW && strb.sel == SEL_LOST) ? wdata : '0;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        pinEn[w]  <= '0;
        irqEn[w]  <= '0;
        loFlag[w] <= '0;
      end else begin
        if (hitW && strb.sel == SEL_PIN) pinEn[w] <= wdata;
        if (hitW && strb.sel == SEL_IRQ) irqEn[w] <= wdata;
        // a new event wins over a clear of the same bit
        loFlag[w] <= (loFlag[w] & ~clrMask) | loEvent[w*DW +: DW];
      end
    end

    assign loFlagV[w*DW +: DW] = loFlag[w];
    assign pinEnV[w*DW +: DW]  = pinEn[w];
    assign irqEnV[w*DW +: DW]  = irqEn[w];
  end

  for (genvar w = 0; w < HI_WORDS; w++) begin : g_hi
    logic [DW-1:0] clrMask;

    assign clrMask = (strb.wrStb && strb.sel == SEL_HIST &&
                      strb.wordIdx == IDX_W'(w)) ? wdata : '0;

    always_ff @(posedge clk) begin
      if (!rstN) hiFlag[w] <= '0;
      else       hiFlag[w] <= (hiFlag[w] & ~clrMask) | hiEvent[w*DW +: DW];
    end

    assign hiFlagV[w*DW +: DW] = hiFlag[w];
  end

  assign pinCause = (|(loFlagV & pinEnV)) || (|hiFlagV);
  assign irq      = |(loFlagV & irqEnV);

  always_comb begin
    rdMux = '0;
    for (int w = 0; w < LO_WORDS; w++) begin
      if (strb.wordIdx == IDX_W'(w)) begin
        if (strb.sel == SEL_PIN)  rdMux = pinEn[w];
        if (strb.sel == SEL_IRQ)  rdMux = irqEn[w];
        if (strb.sel == SEL_LOST) rdMux = loFlag[w];
      end
    end
    for (int w = 0; w < HI_WORDS; w++) begin
      if (strb.wordIdx == IDX_W'(w) && strb.sel == SEL_HIST) rdMux = hiFlag[w];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)           rdata <= '0;
    else if (strb.rdStb) rdata <= rdMux;
  end

  // R3
  lo_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|loEvent) |=> ((loFlagV & $past(loEvent)) == $past(loEvent)));

  // R4
  hi_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|hiEvent) |=> ((hiFlagV & $past(hiEvent)) == $past(hiEvent)));

  // R5
  irq_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((|(loEvent & irqEnV)) && !(strb.wrStb && strb.sel == SEL_IRQ)) |=> irq);

  // R7
  hi_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|hiEvent) |=> pinCause);

endmodule

// File: rtl/err_aggr_top.sv
module err_aggr_top
  import err_aggr_pkg::*;
#(
  parameter int ADDR_W   = 4,
  parameter int DW       = 32,
  parameter int LO_WORDS = 2,
  parameter int HI_WORDS = 2,
  parameter int KEY_VAL  = 5,
  localparam int NLO     = DW * LO_WORDS,
  localparam int NHI     = DW * HI_WORDS
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NLO-1:0]    loEvent,
  input  logic [NHI-1:0]    hiEvent,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DW-1:0]     wdata,
  output logic [DW-1:0]     rdata,
  output logic              errPinN,
  output logic              irq
);

  ctrlStrb_t strb;
  logic      pinCause;
  logic      pinActive;

  err_aggr_ctrl #(
    .ADDR_W(ADDR_W), .DW(DW), .LO_WORDS(LO_WORDS),
    .HI_WORDS(HI_WORDS), .KEY_VAL(KEY_VAL)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wdata(wdata), .pinCause(pinCause), .strb(strb), .pinActive(pinActive)
  );

  err_aggr_datapath #(
    .DW(DW), .LO_WORDS(LO_WORDS), .HI_WORDS(HI_WORDS)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .wdata(wdata),
    .loEvent(loEvent), .hiEvent(hiEvent), .rdata(rdata),
    .pinCause(pinCause), .irq(irq)
  );

  assign errPinN = ~pinActive;

endmodule

// File: tb/err_aggr_top_test.sv
module err_aggr_top_test;

  localparam int DW  = 32;
  localparam int NLO = 64;
  localparam int NHI = 64;
  localparam int A_PIN = 0, A_IRQ = 2, A_LOST = 4, A_HIST = 6, A_KEY = 8;

  // {hi, channel[7:0], pinEn, irqEn, expPinLow, expIrq}
  localparam logic [12:0] VECS [6] = '{
    {1'b0, 8'd6,  1'b1, 1'b1, 1'b1, 1'b1},
    {1'b0, 8'd6,  1'b0, 1'b1, 1'b0, 1'b1},
    {1'b0, 8'd40, 1'b1, 1'b0, 1'b1, 1'b0},
    {1'b0, 8'd40, 1'b0, 1'b0, 1'b0, 1'b0},
    {1'b1, 8'd7,  1'b0, 1'b0, 1'b1, 1'b0},
    {1'b1, 8'd33, 1'b0, 1'b0, 1'b1, 1'b0}
  };

  logic           clk = 1'b0;
  logic           rstN = 1'b0;
  logic [NLO-1:0] loEvent = '0;
  logic [NHI-1:0] hiEvent = '0;
  logic           wrEn = 1'b0, rdEn = 1'b0;
  logic [3:0]     addr = '0;
  logic [DW-1:0]  wdata = '0;
  logic [DW-1:0]  rdata;
  logic           errPinN, irq;

  int  total = 0, bad = 0;
  bit  done = 0;
  logic [DW-1:0] rv;

  always #5 clk = ~clk;

  err_aggr_top uut (
    .clk(clk), .rstN(rstN), .loEvent(loEvent), .hiEvent(hiEvent),
    .wrEn(wrEn), .rdEn(rdEn), .addr(addr), .wdata(wdata),
    .rdata(rdata), .errPinN(errPinN), .irq(irq)
  );

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [DW-1:0] d);
    wrEn = 1'b1; addr = 4'(a); wdata = d;
    @(negedge clk);
    wrEn = 1'b0; wdata = '0;
  endtask

  task automatic rd(input int a, output logic [DW-1:0] d);
    rdEn = 1'b1; addr = 4'(a);
    @(negedge clk);
    rdEn = 1'b0;
    d = rdata;
  endtask

  task automatic pulse(input bit hi, input int ch);
    if (hi) hiEvent[ch] = 1'b1; else loEvent[ch] = 1'b1;
    @(negedge clk);
    hiEvent = '0; loEvent = '0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 pin", 32'(errPinN), 32'd1);
    chk("R1 irq", 32'(irq), 32'd0);
    chk("R1 rdata", rdata, '0);
    rd(A_LOST, rv); chk("R1 status", rv, '0);

    // table of class/enable combinations (R5, R6, R7)
    for (int i = 0; i < 6; i++) begin
      logic [12:0] v;
      int ch, w, b;
      v = VECS[i];
      ch = int'(v[11:4]); w = ch / DW; b = ch % DW;
      if (!v[12]) begin
        wr(A_PIN + w, 32'(v[3]) << b);
        wr(A_IRQ + w, 32'(v[2]) << b);
      end
      pulse(v[12], ch);
      @(negedge clk);
      chk(v[12] ? "R7 pin" : "R6 pin", 32'(errPinN), 32'(!v[1]));
      chk("R5 irq", 32'(irq), 32'(v[0]));
      wr((v[12] ? A_HIST : A_LOST) + w, 32'd1 << b);
      wr(A_KEY, 32'd5);
      chk("R9 release", 32'(errPinN), 32'd1);
      chk("R5 irq cleared", 32'(irq), 32'd0);
      if (!v[12]) begin
        wr(A_PIN + w, '0);
        wr(A_IRQ + w, '0);
      end
    end

    // R2 set, readback, write-one-clear
    pulse(0, 6);
    rd(A_LOST, rv); chk("R2 set", rv, 32'h40);
    wr(A_LOST, 32'h0); rd(A_LOST, rv); chk("R2 zero write", rv, 32'h40);
    wr(A_LOST, 32'h40); rd(A_LOST, rv); chk("R2 clear", rv, 32'h0);

    // R3 set wins over clear in same cycle
    loEvent[3] = 1'b1;
    wr(A_LOST, 32'h8);
    loEvent = '0;
    rd(A_LOST, rv); chk("R3 set wins", rv, 32'h8);
    wr(A_LOST, 32'h8);

    // R4 persistent source re-sets flag
    hiEvent[39] = 1'b1;
    @(negedge clk);
    wr(A_HIST + 1, 32'h80);
    rd(A_HIST + 1, rv); chk("R4 re-set", rv, 32'h80);
    chk("R5 hi no irq", 32'(irq), 32'd0);
    hiEvent = '0;
    wr(A_HIST + 1, 32'h80);
    rd(A_HIST + 1, rv); chk("R4 cleared", rv, 32'h0);
    wr(A_KEY, 32'd5);
    chk("R9 released", 32'(errPinN), 32'd1);

    // R8 late pin enable on pending flag
    pulse(0, 9);
    @(negedge clk);
    chk("R6 not enabled", 32'(errPinN), 32'd1);
    wr(A_PIN, 32'h200);
    chk("R8 before", 32'(errPinN), 32'd1);
    @(negedge clk);
    chk("R8 asserted", 32'(errPinN), 32'd0);

    // R10 key ignored while cause present
    wr(A_KEY, 32'd5);
    @(negedge clk);
    chk("R10 blocked", 32'(errPinN), 32'd0);
    wr(A_LOST, 32'h200);
    @(negedge clk);
    chk("R9 stays low", 32'(errPinN), 32'd0);
    wr(A_KEY, 32'd6);
    chk("R9 wrong key", 32'(errPinN), 32'd0);
    wr(A_KEY, 32'd5);
    chk("R9 right key", 32'(errPinN), 32'd1);

    // R11 register map
    rd(A_PIN, rv); chk("R11 pinEn readback", rv, 32'h200);
    wr(A_IRQ + 1, 32'hA5A5_0001);
    rd(A_IRQ + 1, rv); chk("R11 irqEn readback", rv, 32'hA5A5_0001);
    rd(A_KEY, rv); chk("R11 key reads zero", rv, 32'h0);
    rd(15, rv); chk("R11 unmapped", rv, 32'h0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule